// File: doc/BRIEF.md
# Serial Memory Slave Front-End

This block is the slave side of a byte-wide serial memory's four-wire interface. The external master owns the serial clock. The block captures the command byte, any address bytes and any data bytes from the serial input. It shifts read data or the status byte back out, most significant bit first, with a separate output-enable so that the pad can float. A small status byte holds three bits: a status-protection enable, the write-enable latch and a busy flag. The busy flag models the internal programming time.

Write data is collected in a page buffer while the master is still clocking. When chip select is released, the buffered bytes leave the block as a valid/ready stream toward the memory array. Back-pressure rules for that stream: the block raises `wr_valid` and keeps `wr_addr` and `wr_data` unchanged until it samples `wr_ready` high on a clock edge. Only then does it move to the next byte. The array may hold `wr_ready` low for as long as it needs. Reads use a plain combinational port: the block presents `rd_addr` and expects `rd_data` in the same cycle.

All serial pins are sampled by the system clock `clk`. The serial clock must stay at least four `clk` cycles in each phase, and the serial pins must already be synchronous to `clk`.

Top module: `spi_mem_front`

## Requirements
- R1: While `cs_n` is high, `so_oe` is 0 and serial clock edges, SI data and commands have no effect on the status byte.
- R2: Transfers use clock mode 0, most significant bit first. SI is captured on rising SCK edges. SO changes only after falling SCK edges. The first reply bit is driven after the falling edge that follows the last command or address bit.
- R3: Opcode 0x06 sets the write-enable latch. Opcode 0x04 clears it. The latch is status bit 1.
- R4: Opcode 0x05 returns the status byte: bit 7 is the protection enable, bit 1 the write-enable latch, bit 0 busy, and the other bits 0. The byte repeats for as long as the master keeps clocking.
- R5: Opcode 0x03 is followed by a 16-bit address, high byte first. Address bits at and above `ADDR_BITS` are ignored. Data bytes then stream out from successive addresses, wrapping at the top of the array.
- R6: Opcode 0x02 is followed by a 16-bit address and data bytes. The bytes are written only at the CS rising edge, and only when three things hold: the write-enable latch is set, at least one byte arrived, and the bit count is a multiple of 8. Only the first `PAGE_BYTES` bytes are kept. A commit clears the latch.
- R7: Committed bytes leave on `wr_valid`/`wr_ready` at consecutive addresses, wrapping at the top of the array. Address and data stay stable while the stream is stalled.
- R8: Busy is set from a commit until the stream has drained and a further `WR_CYCLES` cycles have passed. While busy, every opcode other than 0x05 is treated as unrecognized.
- R9: After an unrecognized opcode, SO stays disabled and SI is ignored until the next CS falling edge.
- R10: HOLD changes state only while SCK is low. While held, SCK edges are ignored and SO is disabled. On release, the transfer resumes at the same bit position.
- R11: Opcode 0x01 with one data byte copies bit 7 of that byte into the protection enable at the CS rising edge, but only when the write-enable latch is set. In that case it also clears the latch and starts a busy period. While the protection enable is 0, `wp_n` has no effect.
- R12: While the protection enable is 1, a status write is dropped if `wp_n` was low at any time while CS was low, and the latch stays set. A change of `wp_n` after the CS rising edge has no effect on that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Status write protect, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| rd_addr | output | ADDR_BITS | Array read address |
| rd_data | input | 8 | Array read data, same cycle |
| wr_valid | output | 1 | Write stream byte valid |
| wr_ready | input | 1 | Array accepts the write byte |
| wr_addr | output | ADDR_BITS | Write stream address |
| wr_data | output | 8 | Write stream byte |

## Verification
The bench runs random writes of one to eight bytes at random addresses, with a randomly stalling write stream. Every write is read back. This separates correct byte ordering and address increment from off-by-one buffer indexing and from loss of bytes during stalls. Directed runs cover several invalid writes: no latch, a trailing partial byte, an over-length page, and an address that wraps or carries ignored upper bits. Each one shows whether the commit rules are applied separately. Status writes run against every protect-pin timing, and hold pulses are applied with SCK low and with SCK high. Together these show that protection and pause depend only on the moments the requirements name.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  typedef enum logic [1:0] {PH_OPC, PH_ADDR, PH_DATA, PH_LOCK} phase_e;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
endpackage

// File: rtl/spi_bit_engine.sv
module spi_bit_engine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       si,
  input  logic       hold_n,
  input  logic       stop,
  input  logic [7:0] tx_byte,
  input  logic       tx_en,
  output logic       sel_start,
  output logic       sel_end,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       aligned,
  output logic       so,
  output logic       so_oe
);
  logic       sck_q, cs_q, hold_on, oe_started, so_q;
  logic [2:0] bitcnt;
  logic [6:0] sh;
  logic [7:0] txh;
  logic       live, rise_ev, fall_ev;

  assign sel_start = cs_q & ~cs_n;
  assign sel_end   = ~cs_q & cs_n;
  assign live      = ~cs_n & ~hold_on;
  assign rise_ev   = live & sck & ~sck_q;
  assign fall_ev   = live & ~sck & sck_q;
  assign byte_done = rise_ev & ~stop & (bitcnt == 3'd7);
  assign rx_byte   = {sh, si};
  assign aligned   = (bitcnt == 3'd0);
  assign so        = so_q;
  assign so_oe     = ~cs_n & ~hold_on & oe_started & ~stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q      <= 1'b0;
      cs_q       <= 1'b1;
      hold_on    <= 1'b0;
      bitcnt     <= '0;
      sh         <= '0;
      txh        <= '0;
      so_q       <= 1'b0;
      oe_started <= 1'b0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_n)      hold_on <= 1'b0;
      else if (!sck) hold_on <= ~hold_n;
      if (fall_ev) begin
        if (bitcnt == 3'd0) begin
          txh        <= tx_byte;
          so_q       <= tx_byte[7];
          oe_started <= tx_en;
        end else begin
          so_q <= txh[3'd7 - bitcnt];
        end
      end
      if (sel_start) begin
        bitcnt     <= '0;
        oe_started <= 1'b0;
      end else if (rise_ev && !stop) begin
        sh     <= {sh[5:0], si};
        bitcnt <= bitcnt + 3'd1;
      end
    end
  end

  // R10: the bit position is frozen for as long as the pause is held
  assert_hold_freezes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_on && $past(hold_on) && !cs_n && $past(!cs_n)) |-> $stable(bitcnt));
endmodule

// File: rtl/spi_cmd_unit.sv
module spi_cmd_unit
  import spi_mem_pkg::*;
#(
  parameter int ADDR_BITS = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel_start,
  input  logic                 sel_end,
  input  logic                 byte_done,
  input  logic [7:0]           rx_byte,
  input  logic                 aligned,
  input  logic                 wp_n,
  input  logic                 busy,
  input  logic [7:0]           rd_data,
  output logic                 stop,
  output logic                 tx_en,
  output logic [7:0]           tx_byte,
  output logic [ADDR_BITS-1:0] rd_addr,
  output logic                 push,
  output logic [7:0]           push_data,
  output logic                 commit_wr,
  output logic                 commit_sr,
  output logic [ADDR_BITS-1:0] commit_addr
);
  phase_e      phase;
  logic [7:0]  op;
  logic [15:0] addr;
  logic        abyte, got_data, sr_wpen, wp_low, wel, wpen;
  logic [7:0]  status;
  logic        wp_hit, done_ok;

  assign status      = {wpen, 5'b00000, wel, busy};
  assign wp_hit      = wpen & (wp_low | ~wp_n);
  assign done_ok     = sel_end & aligned & got_data & wel & ~busy & (phase == PH_DATA);
  assign commit_wr   = done_ok & (op == OP_WRITE);
  assign commit_sr   = done_ok & (op == OP_WRSR) & ~wp_hit;
  assign push        = byte_done & (phase == PH_DATA) & (op == OP_WRITE);
  assign push_data   = rx_byte;
  assign rd_addr     = addr[ADDR_BITS-1:0];
  assign commit_addr = addr[ADDR_BITS-1:0];
  assign stop        = (phase == PH_LOCK);
  assign tx_en       = (phase == PH_DATA) & ((op == OP_READ) | (op == OP_RDSR));
  assign tx_byte     = (op == OP_RDSR) ? status : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_LOCK;
      op       <= '0;
      addr     <= '0;
      abyte    <= 1'b0;
      got_data <= 1'b0;
      sr_wpen  <= 1'b0;
      wp_low   <= 1'b0;
      wel      <= 1'b0;
      wpen     <= 1'b0;
    end else if (sel_start) begin
      phase    <= PH_OPC;
      abyte    <= 1'b0;
      got_data <= 1'b0;
      wp_low   <= ~wp_n;
    end else begin
      if (!wp_n) wp_low <= 1'b1;
      if (byte_done) begin
        case (phase)
          PH_OPC: begin
            op <= rx_byte;
            if (busy && rx_byte != OP_RDSR) phase <= PH_LOCK;
            else begin
              case (rx_byte)
                OP_WREN: begin wel <= 1'b1; phase <= PH_LOCK; end
                OP_WRDI: begin wel <= 1'b0; phase <= PH_LOCK; end
                OP_RDSR, OP_WRSR:  phase <= PH_DATA;
                OP_READ, OP_WRITE: phase <= PH_ADDR;
                default:           phase <= PH_LOCK;
              endcase
            end
          end
          PH_ADDR: begin
            addr  <= {addr[7:0], rx_byte};
            abyte <= 1'b1;
            if (abyte) phase <= PH_DATA;
          end
          PH_DATA: begin
            got_data <= 1'b1;
            if (op == OP_WRSR) sr_wpen <= rx_byte[7];
            if (op == OP_READ) addr <= addr + 16'd1;
          end
          default: ;
        endcase
      end
      if (commit_wr) wel <= 1'b0;
      if (commit_sr) begin
        wel  <= 1'b0;
        wpen <= sr_wpen;
      end
    end
  end

  // R11: the protection enable only changes through an enabled status write
  assert_wpen_needs_latch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wpen) |-> $past(wel));
endmodule

// File: rtl/spi_wr_drain.sv
module spi_wr_drain #(
  parameter int ADDR_BITS  = 15,
  parameter int PAGE_BYTES = 8,
  parameter int WR_CYCLES  = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 push,
  input  logic [7:0]           push_data,
  input  logic                 commit_wr,
  input  logic                 commit_sr,
  input  logic [ADDR_BITS-1:0] commit_addr,
  input  logic                 wr_ready,
  output logic                 wr_valid,
  output logic [ADDR_BITS-1:0] wr_addr,
  output logic [7:0]           wr_data,
  output logic                 busy
);
  localparam int CW = $clog2(PAGE_BYTES + 1);
  localparam int IW = $clog2(PAGE_BYTES);
  localparam int TW = $clog2(WR_CYCLES + 1);
  localparam logic [CW-1:0] PAGE_C = CW'(PAGE_BYTES);
  localparam logic [TW-1:0] TMR_C  = TW'(WR_CYCLES);

  logic [7:0]           pbuf [PAGE_BYTES];
  logic [CW-1:0]        fill, dlen, didx;
  logic [ADDR_BITS-1:0] base;
  logic                 draining, last_beat;
  logic [TW-1:0]        tmr;

  assign wr_valid  = draining;
  assign wr_addr   = base + ADDR_BITS'(didx);
  assign wr_data   = pbuf[didx[IW-1:0]];
  assign busy      = draining | (tmr != '0);
  assign last_beat = draining & wr_ready & (didx == dlen - CW'(1));

  always_ff @(posedge clk) begin
    if (push && fill < PAGE_C) pbuf[fill[IW-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill     <= '0;
      dlen     <= '0;
      didx     <= '0;
      base     <= '0;
      draining <= 1'b0;
      tmr      <= '0;
    end else begin
      if (clear) fill <= '0;
      else if (push && fill < PAGE_C) fill <= fill + CW'(1);
      if (commit_wr) begin
        draining <= 1'b1;
        didx     <= '0;
        dlen     <= fill;
        base     <= commit_addr;
      end else if (draining && wr_ready) begin
        didx <= didx + CW'(1);
        if (last_beat) draining <= 1'b0;
      end
      if (commit_sr || last_beat) tmr <= TMR_C;
      else if (tmr != '0)         tmr <= tmr - TW'(1);
    end
  end

  // R7: a stalled byte keeps its address and data
  assert_stall_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  // R8: a commit from the command side always raises busy
  assert_commit_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_wr || commit_sr) |=> busy);
endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front #(
  parameter int ADDR_BITS  = 15,
  parameter int PAGE_BYTES = 8,
  parameter int WR_CYCLES  = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sck,
  input  logic                 cs_n,
  input  logic                 si,
  input  logic                 hold_n,
  input  logic                 wp_n,
  output logic                 so,
  output logic                 so_oe,
  output logic [ADDR_BITS-1:0] rd_addr,
  input  logic [7:0]           rd_data,
  output logic                 wr_valid,
  input  logic                 wr_ready,
  output logic [ADDR_BITS-1:0] wr_addr,
  output logic [7:0]           wr_data
);
  logic                 sel_start, sel_end, byte_done, aligned, stop, tx_en;
  logic [7:0]           rx_byte, tx_byte, push_data;
  logic                 push, commit_wr, commit_sr, busy;
  logic [ADDR_BITS-1:0] commit_addr;

  spi_bit_engine u_eng (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .stop(stop), .tx_byte(tx_byte), .tx_en(tx_en), .sel_start(sel_start),
    .sel_end(sel_end), .byte_done(byte_done), .rx_byte(rx_byte),
    .aligned(aligned), .so(so), .so_oe(so_oe)
  );

  spi_cmd_unit #(.ADDR_BITS(ADDR_BITS)) u_cmd (
    .clk(clk), .rst_n(rst_n), .sel_start(sel_start), .sel_end(sel_end),
    .byte_done(byte_done), .rx_byte(rx_byte), .aligned(aligned), .wp_n(wp_n),
    .busy(busy), .rd_data(rd_data), .stop(stop), .tx_en(tx_en),
    .tx_byte(tx_byte), .rd_addr(rd_addr), .push(push), .push_data(push_data),
    .commit_wr(commit_wr), .commit_sr(commit_sr), .commit_addr(commit_addr)
  );

  spi_wr_drain #(.ADDR_BITS(ADDR_BITS), .PAGE_BYTES(PAGE_BYTES),
                 .WR_CYCLES(WR_CYCLES)) u_drain (
    .clk(clk), .rst_n(rst_n), .clear(sel_start), .push(push),
    .push_data(push_data), .commit_wr(commit_wr), .commit_sr(commit_sr),
    .commit_addr(commit_addr), .wr_ready(wr_ready), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy)
  );
endmodule

// File: tb/spi_mem_front_test.sv
module spi_mem_front_test;
  localparam int AW = 10;
  localparam int PG = 8;
  localparam int WC = 300;
  localparam int MASK = (1 << AW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic hold_n = 1'b1, wp_n = 1'b1, wr_ready = 1'b0;
  logic so, so_oe, wr_valid;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic [7:0] mem [1 << AW];
  logic [7:0] expm [1 << AW];
  logic [7:0] wbuf [16];
  int nchk = 0, nerr = 0;
  logic [31:0] seed;

  always #2 clk = ~clk;

  spi_mem_front #(.ADDR_BITS(AW), .PAGE_BYTES(PG), .WR_CYCLES(WC)) uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .wp_n(wp_n), .so(so), .so_oe(so_oe), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assign rd_data = mem[rd_addr];
  always @(posedge clk) if (wr_valid && wr_ready) mem[wr_addr] <= wr_data;
  always @(negedge clk) wr_ready <= ($urandom % 3) != 0;

  function automatic logic [7:0] init_val(int a);
    return 8'(a * 37 + 11);
  endfunction
  function automatic logic [7:0] stat(logic wpen, logic wel, logic bsy);
    return {wpen, 5'b0, wel, bsy};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (4) @(negedge clk);
  endtask
  task automatic bit_x(input logic b, output logic r, output logic oe);
    si = b; half(); r = so; oe = so_oe; sck = 1'b1; half(); sck = 1'b0;
  endtask
  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                      output logic oe_all, output logic oe_any);
    logic r, oe;
    oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      bit_x(tx[i], r, oe); rx[i] = r; oe_all &= oe; oe_any |= oe;
    end
  endtask
  task automatic sel(); cs_n = 1'b0; half(); endtask
  task automatic desel(); half(); cs_n = 1'b1; half(); half(); endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] d; logic a, o;
    xfer(b, d, a, o);
  endtask
  task automatic cmd1(input logic [7:0] b); sel(); send(b); desel(); endtask
  task automatic rdsr(output logic [7:0] s);
    logic a, o;
    sel(); send(8'h05); xfer(8'h00, s, a, o); desel();
  endtask
  task automatic wait_idle(output logic [7:0] s);
    for (int k = 0; k < 100; k++) begin
      rdsr(s);
      if (!s[0]) break;
    end
  endtask
  task automatic wrsr(input logic [7:0] v); sel(); send(8'h01); send(v); desel(); endtask

  task automatic do_write(input logic [15:0] a, input int n, input int tail);
    logic r, oe;
    sel(); send(8'h02); send(a[15:8]); send(a[7:0]);
    for (int i = 0; i < n; i++) send(wbuf[i]);
    for (int j = 0; j < tail; j++) bit_x(1'b1, r, oe);
    desel();
  endtask
  task automatic model_write(input logic [15:0] a, input int n);
    for (int i = 0; i < n && i < PG; i++) expm[(int'(a) + i) & MASK] = wbuf[i];
  endtask
  task automatic read_check(string req, input logic [15:0] a, input int n);
    logic [7:0] d; logic oa, on;
    sel(); send(8'h03); send(a[15:8]); send(a[7:0]);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, d, oa, on);
      chk(req, {24'h0, d}, {24'h0, expm[(int'(a) + i) & MASK]});
      if (i == 0) chk({req, " oe"}, {31'h0, oa}, 32'd1);
    end
    desel();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] s, d;
    logic oa, on, r, oe;
    logic [15:0] a;
    int n;
    seed = $urandom(32'd2024);
    for (int i = 0; i < (1 << AW); i++) begin
      mem[i] = init_val(i); expm[i] = init_val(i);
    end
    repeat (5) @(negedge clk);
    chk("R1 reset oe", {31'h0, so_oe}, 32'd0);
    chk("R7 reset valid", {31'h0, wr_valid}, 32'd0);
    rst_n = 1'b1;
    half();

    rdsr(s); chk("R4 status after reset", {24'h0, s}, {24'h0, stat(0, 0, 0)});
    cmd1(8'h06); rdsr(s); chk("R3 wren", {24'h0, s}, {24'h0, stat(0, 1, 0)});
    sel(); send(8'h05); xfer(8'h00, s, oa, on); xfer(8'h00, d, oa, on); desel();
    chk("R4 repeated status", {24'h0, d}, {24'h0, stat(0, 1, 0)});
    chk("R2 reply driven", {31'h0, oa}, 32'd1);
    cmd1(8'h04); rdsr(s); chk("R3 wrdi", {24'h0, s}, {24'h0, stat(0, 0, 0)});

    // R1: clocking with chip select high changes nothing
    si = 1'b1;
    for (int k = 0; k < 10; k++) begin
      sck = 1'b1; half(); sck = 1'b0; half();
      if (k == 5) chk("R1 deselected oe", {31'h0, so_oe}, 32'd0);
    end
    rdsr(s); chk("R1 status untouched", {24'h0, s}, {24'h0, stat(0, 0, 0)});

    // R6: write without the latch is not committed
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hA0 + 8'(i);
    do_write(16'h0040, 4, 0); half();
    read_check("R6 no latch", 16'h0040, 4);

    // R6/R7/R8: enabled write, busy, latch cleared, commands locked while busy
    cmd1(8'h06); do_write(16'h0010, 4, 0); model_write(16'h0010, 4);
    rdsr(s); chk("R8 busy after commit", {24'h0, s}, {24'h0, stat(0, 0, 1)});
    cmd1(8'h06);
    sel(); send(8'h03); send(8'h00); send(8'h10); xfer(8'h00, d, oa, on); desel();
    chk("R8 read locked while busy", {31'h0, on}, 32'd0);
    wait_idle(s); chk("R8 idle and latch clear", {24'h0, s}, {24'h0, stat(0, 0, 0)});
    read_check("R7 written bytes", 16'h0010, 4);

    // R6: trailing partial byte prevents commit, latch stays
    cmd1(8'h06); wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    do_write(16'h0080, 2, 3); rdsr(s);
    chk("R6 partial byte", {24'h0, s}, {24'h0, stat(0, 1, 0)});
    read_check("R6 partial no write", 16'h0080, 2);

    // R6: over-length page keeps only PG bytes
    for (int i = 0; i < 10; i++) wbuf[i] = 8'h50 + 8'(i);
    do_write(16'h0100, 10, 0); model_write(16'h0100, 10); wait_idle(s);
    read_check("R6 page limit", 16'h0100, 10);

    // R5/R7: wrap at top and ignored upper address bits
    cmd1(8'h06); for (int i = 0; i < 4; i++) wbuf[i] = 8'hC0 + 8'(i);
    do_write(16'h03FE, 4, 0); model_write(16'h03FE, 4); wait_idle(s);
    read_check("R7 wrap write", 16'h03FE, 4);
    read_check("R5 upper bits ignored", 16'hFC10, 2);

    // R9: unrecognized opcode locks out
    sel(); send(8'hFF); xfer(8'h06, d, oa, on); xfer(8'h00, d, oa, on); desel();
    chk("R9 so disabled", {31'h0, on}, 32'd0);
    rdsr(s); chk("R9 later bytes ignored", {24'h0, s}, {24'h0, stat(0, 0, 0)});

    // R10/R2: pause mid byte, with SCK low and with SCK high
    a = 16'h0013;
    sel(); send(8'h03); send(a[15:8]); send(a[7:0]);
    for (int i = 7; i >= 5; i--) begin bit_x(1'b0, r, oe); d[i] = r; end
    hold_n = 1'b0; half();
    chk("R10 held oe", {31'h0, so_oe}, 32'd0);
    for (int k = 0; k < 5; k++) begin sck = 1'b1; half(); sck = 1'b0; half(); end
    hold_n = 1'b1; half();
    for (int i = 4; i >= 0; i--) begin bit_x(1'b0, r, oe); d[i] = r; end
    chk("R10 byte after pause", {24'h0, d}, {24'h0, expm[19]});
    si = 1'b0; half(); d[7] = so; sck = 1'b1; half(); hold_n = 1'b0; half();
    chk("R10 no pause while sck high", {31'h0, so_oe}, 32'd1);
    sck = 1'b0; half();
    chk("R10 pause at sck low", {31'h0, so_oe}, 32'd0);
    hold_n = 1'b1; half();
    for (int i = 6; i >= 0; i--) begin bit_x(1'b0, r, oe); d[i] = r; end
    desel();
    chk("R10 second byte", {24'h0, d}, {24'h0, expm[20]});

    // R11/R12: status protection
    wp_n = 1'b0; cmd1(8'h06); wrsr(8'h80); wait_idle(s);
    chk("R11 wp ignored when disabled", {24'h0, s}, {24'h0, stat(1, 0, 0)});
    cmd1(8'h06); wrsr(8'h00); rdsr(s);
    chk("R12 inhibited by wp", {24'h0, s}, {24'h0, stat(1, 1, 0)});
    wp_n = 1'b1;
    sel(); send(8'h01); wp_n = 1'b0; half(); wp_n = 1'b1; send(8'h00); desel();
    rdsr(s); chk("R12 wp pulse aborts", {24'h0, s}, {24'h0, stat(1, 1, 0)});
    wrsr(8'h00); wp_n = 1'b0; rdsr(s);
    chk("R12 wp after start", {24'h0, s}, {24'h0, stat(0, 0, 1)});
    wp_n = 1'b1; wait_idle(s);
    chk("R11 cleared enable", {24'h0, s}, {24'h0, stat(0, 0, 0)});

    // R6/R7 random writes with stalling stream
    for (int it = 0; it < 20; it++) begin
      a = 16'($urandom); n = 1 + int'($urandom % PG);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      cmd1(8'h06); do_write(a, n, 0); model_write(a, n); wait_idle(s);
      read_check("R7 random", a, n);
    end

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule